// File: doc/BRIEF.md
# Multi-Packet IN Transfer Splitter

This block sits on the device side of a USB IN endpoint, between the software that sets up a transfer and the serial engine that moves packets on the bus. Software gives it one total byte count, the endpoint's maximum packet size and a flag that asks for a trailing zero-length packet, then pulses a start strobe. The block then offers the serial engine one packet length at a time. Each length is the endpoint size or the bytes still left, whichever is smaller. It keeps its own count of the bytes already delivered.

The serial engine reports two events. A token means the host has asked for the current packet. An ACK means the host took it. Only an ACK that follows a token moves the transfer forward. A token with no ACK offers the same packet again. The block decides on its own when the transfer has ended: after a short packet, after the last full packet when the total is an exact multiple of the packet size, or after one extra empty packet when that option is on. When the transfer ends, the sent-bytes count returns to zero and a done flag is raised. The flag stays set until software clears it.

Top module: `mis_splitter`

## Requirements
- R1: A start pulse while idle captures the total, packet size and zero-length option, raises busy in the next cycle and leaves the sent-bytes count at 0.
- R2: While busy in the data phase, pkt_len equals the smaller of the packet size and (total minus sent bytes). In the zero-length phase pkt_len is 0, and while idle it is 0.
- R3: An ACK that follows a token for the current packet adds the current pkt_len to the sent-bytes count. The count never exceeds the total.
- R4: A token without an ACK, or an ACK that no token preceded, leaves the sent-bytes count and pkt_len unchanged. The same packet is offered again.
- R5: An accepted packet shorter than the packet size ends the transfer. In the next cycle busy is 0, done is 1 and the sent-bytes count is 0. A total that is not a multiple of the packet size therefore ends with a short final packet.
- R6: When the total is an exact nonzero multiple of the packet size and the zero-length option is off, the transfer ends on the ACK of the last full packet.
- R7: When the total is an exact nonzero multiple of the packet size and the zero-length option is on, exactly one extra packet of length 0 follows the last full packet. The transfer ends on its ACK.
- R8: The done flag stays 1 until a done_clr pulse while it is set. If the transfer ends in the same cycle as a done_clr pulse, the flag is 1 afterwards.
- R9: A start pulse while busy is ignored. The captured configuration, pkt_len and the sent-bytes count are unaffected.
- R10: A total of 0 gives a single zero-length packet, which ends the transfer as a short packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_total | input | CNT_W | Total bytes of the transfer |
| cfg_ep_size | input | SIZE_W | Maximum packet size of the endpoint (nonzero) |
| cfg_auto_zlp | input | 1 | Append a zero-length packet after an exact-multiple total |
| cfg_start | input | 1 | One-cycle pulse that starts a transfer |
| done_clr | input | 1 | Write-one pulse that clears the done flag |
| tok_in | input | 1 | Host token for the current packet seen by the serial engine |
| ack_in | input | 1 | Host ACK for the packet seen by the serial engine |
| pkt_len | output | SIZE_W | Length of the packet to send now |
| busy | output | 1 | A transfer is in progress |
| sent_bytes | output | CNT_W | Bytes acknowledged so far in this transfer |
| xfer_done | output | 1 | Sticky transfer-complete flag |

## Verification
The assertions assume that cfg_ep_size is nonzero whenever a transfer is started. They also assume that token and ACK events arrive one per cycle at most, with each ACK coming after the token of the packet it answers. The bench keeps to this: every start it issues uses a nonzero packet size. It raises tok_in and ack_in in separate cycles, except where it deliberately sends an unmatched token or an unmatched ACK to exercise the retry and ignore behaviour.

// File: rtl/mis_pkg.sv
package mis_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_ZLP  = 2'd2
  } mis_state_e;
endpackage

// File: rtl/mis_len_sel.sv
module mis_len_sel #(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11
) (
  input  logic              busy,
  input  logic              in_zlp,
  input  logic [CNT_W-1:0]  total_q,
  input  logic [CNT_W-1:0]  sent_q,
  input  logic [SIZE_W-1:0] size_q,
  output logic [SIZE_W-1:0] cur_len
);
  localparam int PAD_W = CNT_W - SIZE_W;

  // smaller of remaining bytes and packet size
  function automatic logic [SIZE_W-1:0] pick_len(
    input logic [CNT_W-1:0]  remain,
    input logic [SIZE_W-1:0] size
  );
    logic [CNT_W-1:0] size_ext;
    size_ext = {{PAD_W{1'b0}}, size};
    if (remain < size_ext) pick_len = remain[SIZE_W-1:0];
    else                   pick_len = size;
  endfunction

  logic [CNT_W-1:0] remain;
  assign remain = total_q - sent_q;

  always_comb begin
    if (!busy || in_zlp) cur_len = '0;
    else                 cur_len = pick_len(remain, size_q);
  end
endmodule

// File: rtl/mis_seq.sv
module mis_seq
  import mis_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_total,
  input  logic [SIZE_W-1:0] cfg_ep_size,
  input  logic              cfg_auto_zlp,
  input  logic              cfg_start,
  input  logic              tok_in,
  input  logic              ack_in,
  input  logic [SIZE_W-1:0] cur_len,
  output logic [CNT_W-1:0]  total_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [CNT_W-1:0]  sent_q,
  output logic              busy,
  output logic              in_zlp,
  output logic              armed,
  output logic              start_evt,
  output logic              acc_evt,
  output logic              fin_evt
);
  localparam int PAD_W = CNT_W - SIZE_W;

  function automatic logic [CNT_W-1:0] add_len(
    input logic [CNT_W-1:0]  base,
    input logic [SIZE_W-1:0] len
  );
    add_len = base + {{PAD_W{1'b0}}, len};
  endfunction

  mis_state_e       state;
  logic             zlp_q;
  logic             is_short;
  logic             hit_total;
  logic             to_zlp;
  logic [CNT_W-1:0] sum;

  assign busy      = (state != ST_IDLE);
  assign in_zlp    = (state == ST_ZLP);
  assign start_evt = cfg_start && !busy;
  assign acc_evt   = busy && armed && ack_in;
  assign sum       = add_len(sent_q, cur_len);
  assign is_short  = (cur_len < size_q);
  assign hit_total = (sum == total_q);
  assign fin_evt   = acc_evt && (is_short || (hit_total && !zlp_q));
  assign to_zlp    = acc_evt && !is_short && hit_total && zlp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      total_q <= '0;
      size_q  <= '0;
      zlp_q   <= 1'b0;
      sent_q  <= '0;
      armed   <= 1'b0;
    end else begin
      if (start_evt) begin
        state   <= ST_DATA;
        total_q <= cfg_total;
        size_q  <= cfg_ep_size;
        zlp_q   <= cfg_auto_zlp;
        sent_q  <= '0;
        armed   <= 1'b0;
      end else if (fin_evt) begin
        state  <= ST_IDLE;
        sent_q <= '0;
        armed  <= 1'b0;
      end else if (acc_evt) begin
        sent_q <= sum;
        armed  <= 1'b0;
        if (to_zlp) state <= ST_ZLP;
      end else if (busy && tok_in) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mis_done_flag.sv
module mis_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic fin_evt,
  input  logic done_clr,
  output logic xfer_done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        xfer_done <= 1'b0;
    else if (fin_evt)  xfer_done <= 1'b1;
    else if (done_clr) xfer_done <= 1'b0;
  end
endmodule

// File: rtl/mis_splitter.sv
module mis_splitter #(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_total,
  input  logic [SIZE_W-1:0] cfg_ep_size,
  input  logic              cfg_auto_zlp,
  input  logic              cfg_start,
  input  logic              done_clr,
  input  logic              tok_in,
  input  logic              ack_in,
  output logic [SIZE_W-1:0] pkt_len,
  output logic              busy,
  output logic [CNT_W-1:0]  sent_bytes,
  output logic              xfer_done
);
  logic [CNT_W-1:0]  total_q;
  logic [SIZE_W-1:0] size_q;
  logic [CNT_W-1:0]  sent_q;
  logic [SIZE_W-1:0] cur_len;
  logic              in_zlp;
  logic              armed;
  logic              start_evt;
  logic              acc_evt;
  logic              fin_evt;

  mis_len_sel #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_len (
    .busy    (busy),
    .in_zlp  (in_zlp),
    .total_q (total_q),
    .sent_q  (sent_q),
    .size_q  (size_q),
    .cur_len (cur_len)
  );

  mis_seq #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_total    (cfg_total),
    .cfg_ep_size  (cfg_ep_size),
    .cfg_auto_zlp (cfg_auto_zlp),
    .cfg_start    (cfg_start),
    .tok_in       (tok_in),
    .ack_in       (ack_in),
    .cur_len      (cur_len),
    .total_q      (total_q),
    .size_q       (size_q),
    .sent_q       (sent_q),
    .busy         (busy),
    .in_zlp       (in_zlp),
    .armed        (armed),
    .start_evt    (start_evt),
    .acc_evt      (acc_evt),
    .fin_evt      (fin_evt)
  );

  mis_done_flag u_done (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_evt   (fin_evt),
    .done_clr  (done_clr),
    .xfer_done (xfer_done)
  );

  assign pkt_len    = cur_len;
  assign sent_bytes = sent_q;
endmodule

// File: rtl/mis_splitter_chk.sv
module mis_splitter_chk #(
  parameter int CNT_W  = 16,
  parameter int SIZE_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic              done_clr,
  input logic [SIZE_W-1:0] pkt_len,
  input logic              busy,
  input logic [CNT_W-1:0]  sent_bytes,
  input logic              xfer_done,
  input logic [CNT_W-1:0]  total_q,
  input logic [SIZE_W-1:0] size_q,
  input logic              start_evt,
  input logic              acc_evt,
  input logic              fin_evt
);
  localparam int PAD_W = CNT_W - SIZE_W;

  logic [CNT_W-1:0] len_ext;
  assign len_ext = {{PAD_W{1'b0}}, pkt_len};

  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy && (sent_bytes == '0));

  assert_len_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pkt_len <= size_q));

  assert_idle_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pkt_len == '0));

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_evt && !fin_evt) |=> (sent_bytes == $past(sent_bytes) + $past(len_ext)));

  assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (sent_bytes + len_ext <= total_q));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acc_evt) |=> ($stable(sent_bytes) && $stable(pkt_len)));

  assert_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fin_evt |=> (!busy && xfer_done && (sent_bytes == '0)));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !done_clr) |=> xfer_done);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_evt && done_clr) |=> xfer_done);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_start) |=> ($stable(total_q) && $stable(size_q)));
endmodule

bind mis_splitter mis_splitter_chk #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_start  (cfg_start),
  .done_clr   (done_clr),
  .pkt_len    (pkt_len),
  .busy       (busy),
  .sent_bytes (sent_bytes),
  .xfer_done  (xfer_done),
  .total_q    (total_q),
  .size_q     (size_q),
  .start_evt  (start_evt),
  .acc_evt    (acc_evt),
  .fin_evt    (fin_evt)
);

// File: tb/mis_splitter_bench.sv
module mis_splitter_bench;
  localparam int CNT_W  = 16;
  localparam int SIZE_W = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cfg_total = '0;
  logic [SIZE_W-1:0] cfg_ep_size = '0;
  logic              cfg_auto_zlp = 1'b0;
  logic              cfg_start = 1'b0;
  logic              done_clr = 1'b0;
  logic              tok_in = 1'b0;
  logic              ack_in = 1'b0;
  logic [SIZE_W-1:0] pkt_len;
  logic              busy;
  logic [CNT_W-1:0]  sent_bytes;
  logic              xfer_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  int exp_q[$];
  int plan[$];
  int acc;

  always #4 clk = ~clk;

  mis_splitter #(.CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_mis_splitter (
    .clk(clk), .rst_n(rst_n), .cfg_total(cfg_total), .cfg_ep_size(cfg_ep_size),
    .cfg_auto_zlp(cfg_auto_zlp), .cfg_start(cfg_start), .done_clr(done_clr),
    .tok_in(tok_in), .ack_in(ack_in), .pkt_len(pkt_len), .busy(busy),
    .sent_bytes(sent_bytes), .xfer_done(xfer_done)
  );

  task automatic check(input string req, input int got, input int want);
    n_chk++;
    if (got != want) begin
      n_bad++;
      $display("FAIL %s got=%0d want=%0d", req, got, want);
    end
  endtask

  // packet list restated from the requirements
  task automatic build_plan(input int total, input int size, input bit zlp);
    int rem;
    plan.delete();
    rem = total;
    forever begin
      int l;
      l = (rem < size) ? rem : size;
      plan.push_back(l);
      rem -= l;
      if (l < size) break;
      if (rem == 0) begin
        if (zlp) plan.push_back(0);
        break;
      end
    end
  endtask

  // monitor: each offered token pops one expected length
  always begin
    @(negedge clk);
    #1;
    if (tok_in && busy) begin
      if (exp_q.size() == 0) check("R2 unexpected token", 1, 0);
      else check("R2 pkt_len", int'(pkt_len), exp_q.pop_front());
    end
  end

  task automatic do_start(input int total, input int size, input bit zlp);
    @(negedge clk);
    cfg_total = CNT_W'(total);
    cfg_ep_size = SIZE_W'(size);
    cfg_auto_zlp = zlp;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    check("R1 busy after start", int'(busy), 1);
    check("R1 sent zero after start", int'(sent_bytes), 0);
    acc = 0;
  endtask

  // one packet: token (optionally twice), then ack
  task automatic do_pkt(input int len, input bit last, input bit retry, input bit clr);
    @(negedge clk);
    exp_q.push_back(len);
    tok_in = 1'b1;
    if (retry) begin
      @(negedge clk);
      exp_q.push_back(len);
      check("R4 sent held on token retry", int'(sent_bytes), acc);
    end
    @(negedge clk);
    tok_in = 1'b0;
    ack_in = 1'b1;
    done_clr = clr;
    @(negedge clk);
    ack_in = 1'b0;
    done_clr = 1'b0;
    acc += len;
    if (last) begin
      check("R5 busy low at end", int'(busy), 0);
      check("R5 done set at end", int'(xfer_done), 1);
      check("R5 sent cleared at end", int'(sent_bytes), 0);
    end else begin
      check("R3 sent advanced", int'(sent_bytes), acc);
    end
  endtask

  task automatic run_plan(input bit clr_last);
    for (int i = 0; i < plan.size(); i++)
      do_pkt(plan[i], i == plan.size() - 1, 1'b0, clr_last && (i == plan.size() - 1));
  endtask

  task automatic clear_done();
    @(negedge clk);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R8 reset done", int'(xfer_done), 0);
    check("R2 idle pkt_len", int'(pkt_len), 0);
    check("R3 reset sent", int'(sent_bytes), 0);

    // R5: non-multiple total ends with short packet
    build_plan(200, 64, 1'b0);
    check("R5 plan length", plan.size(), 4);
    do_start(200, 64, 1'b0);
    run_plan(1'b0);
    repeat (3) @(negedge clk);
    check("R8 done held", int'(xfer_done), 1);
    clear_done();
    check("R8 done cleared", int'(xfer_done), 0);

    // R6: exact multiple, no zero-length packet
    build_plan(128, 64, 1'b0);
    do_start(128, 64, 1'b0);
    run_plan(1'b0);
    check("R6 no extra packet", exp_q.size(), 0);
    clear_done();

    // R7: exact multiple with zero-length packet
    build_plan(192, 64, 1'b1);
    check("R7 plan has empty tail", plan[plan.size()-1], 0);
    do_start(192, 64, 1'b1);
    do_pkt(64, 1'b0, 1'b0, 1'b0);
    do_pkt(64, 1'b0, 1'b0, 1'b0);
    do_pkt(64, 1'b0, 1'b0, 1'b0);
    check("R7 still busy before empty packet", int'(busy), 1);
    check("R7 empty packet offered", int'(pkt_len), 0);
    do_pkt(0, 1'b1, 1'b0, 1'b0);
    clear_done();

    // R5: single short packet with zlp option on
    build_plan(40, 64, 1'b1);
    do_start(40, 64, 1'b1);
    run_plan(1'b0);
    clear_done();

    // R10: zero total
    build_plan(0, 8, 1'b1);
    check("R10 single empty packet", plan.size(), 1);
    do_start(0, 8, 1'b1);
    check("R10 empty length", int'(pkt_len), 0);
    run_plan(1'b0);

    // R4 and R9 inside one transfer; done left set from before
    do_start(100, 32, 1'b0);
    do_pkt(32, 1'b0, 1'b1, 1'b0);
    // stray ack with no token
    @(negedge clk);
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    check("R4 stray ack sent held", int'(sent_bytes), 32);
    check("R4 stray ack len held", int'(pkt_len), 32);
    // start while busy
    @(negedge clk);
    cfg_total = 16'd5;
    cfg_ep_size = 11'd4;
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    check("R9 sent unaffected", int'(sent_bytes), 32);
    check("R9 len unaffected", int'(pkt_len), 32);
    do_pkt(32, 1'b0, 1'b0, 1'b0);
    do_pkt(32, 1'b0, 1'b0, 1'b0);
    check("R2 final short length", int'(pkt_len), 4);
    // R8: done_clr in the finishing cycle, set wins
    check("R8 done still set", int'(xfer_done), 1);
    do_pkt(4, 1'b1, 1'b0, 1'b1);
    clear_done();
    check("R8 cleared at end", int'(xfer_done), 0);
    check("R2 queue drained", exp_q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got=hung want=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule